// File: doc/BRIEF.md
# Snooping Cache Coherence Controller

This block keeps the coherence state of a small direct-mapped cache that sits on a shared bus with other caching agents. The cache writes back and invalidates on writes. Each line is Invalid, Shared (clean and readable) or Exclusive (the only copy, dirty and writable). The block compares the tag of each CPU access and answers it at once when the line state allows. Otherwise it asks for the bus, waits for a grant and issues the needed commands: a write-back of a dirty victim first when there is one, then a read miss or a write miss. A write to a clean Shared line is a plain write miss, because there is no upgrade command.

At the same time the block watches read-miss and write-miss commands that other agents put on the bus. A snoop that finds the block dirty here makes the block supply it: the block raises an abort so that memory does not answer, and it presents the block address. The snoop then downgrades or invalidates the line. Snoops take priority over the CPU. While the block waits for a grant, a snoop that hits the pending line is handled first, and the request is then restarted from the new line state.

The CPU keeps a request steady until the block reports completion. Addresses are block addresses. The low IDX_W bits select the line, and the remaining bits are the tag.

Top module: `snoop_coh_ctrl`

## Requirements
- R1: After reset every line is Invalid, so any first access misses, and bus_req, bus_cmd_valid, snp_abort and cpu_done are all low.
- R2: A read to a matching line in Shared or Exclusive, or a write to a matching Exclusive line, raises cpu_done in the cycle the request is presented and leaves bus_req low.
- R3: A read miss raises bus_req in the next cycle. After the grant it issues command 1 (read miss) with the request address, raises cpu_done in that same cycle, and leaves the line Shared with the new tag.
- R4: A write to an Invalid line, to a Shared line, or to a line whose tag differs issues command 2 (write miss) after the grant, with cpu_done in that same cycle, and leaves the line Exclusive.
- R5: When the victim line is Exclusive with a different tag, the cycle after the grant carries command 3 (write-back) with the victim address {old tag, index}. The miss command follows in the next cycle.
- R6: While it waits for a grant the block holds bus_req high, issues no command and changes no line state. bus_req and bus_cmd_valid fall once the access is complete.
- R7: A snooped read miss (snp_cmd 1) that matches an Exclusive line pulses snp_abort in the next cycle, with snp_wb_addr equal to the snooped address, and leaves the line Shared.
- R8: A snooped write miss (snp_cmd 2) that matches a Shared or Exclusive line leaves it Invalid. snp_abort pulses only when the line was Exclusive.
- R9: A snoop with a tag that does not match, a snoop to an Invalid line, a snooped read miss to a Shared line, or snp_cmd 0 or 3 changes no state and raises no abort.
- R10: A snoop that matches the line of a request waiting for its grant is applied first. bus_req then drops for exactly one cycle and the request restarts with the updated line state. A snoop that does not match keeps the wait going.
- R11: A snoop in the same cycle as a CPU request stalls the CPU side for that cycle, so cpu_done stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | CPU access request, held until cpu_done |
| cpu_req_write | input | 1 | 1 for a write, 0 for a read |
| cpu_req_addr | input | ADDR_W | Block address of the access |
| cpu_done | output | 1 | Access completes in this cycle |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | One-cycle grant from the arbiter |
| bus_cmd_valid | output | 1 | Command strobe, one cycle per command |
| bus_cmd | output | 2 | 1 read miss, 2 write miss, 3 write-back |
| bus_cmd_addr | output | ADDR_W | Address of the command |
| snp_valid | input | 1 | Snooped transaction from another agent |
| snp_cmd | input | 2 | Snooped command: 1 read miss, 2 write miss |
| snp_addr | input | ADDR_W | Snooped block address |
| snp_abort | output | 1 | Abort the memory access; this cache supplies the block |
| snp_wb_addr | output | ADDR_W | Address of the block being supplied |

## Verification
Timing decides every check. A hit shows on cpu_done combinationally in the cycle the request is driven. bus_req rises one cycle after a miss is presented. The first command comes one cycle after the grant, and a write-back pushes the miss command and cpu_done back one cycle more. snp_abort appears one cycle after the snoop. The bench drives all inputs at the falling edge and samples at the falling edge of the exact cycle each result is due. A reference model of line states and tags advances at the rising edge where the block commits. Silent cases, such as ignored snoops and stalled CPU requests, are observed through later hit or miss outcomes and the abort output.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {
    LN_INV = 2'd0,
    LN_SHR = 2'd1,
    LN_EXC = 2'd2
  } line_st_e;

  typedef enum logic [1:0] {
    BC_NONE   = 2'd0,
    BC_RDMISS = 2'd1,
    BC_WRMISS = 2'd2,
    BC_WRBACK = 2'd3
  } bus_cmd_e;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_ARB  = 2'd1,
    FS_WBK  = 2'd2,
    FS_MISS = 2'd3
  } fsm_e;
endpackage

// File: rtl/coh_rst_sync.sv
module coh_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/coh_line_table.sv
module coh_line_table
  import coh_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int IDX_W  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [IDX_W-1:0]        cpu_idx,
  output line_st_e                cpu_st,
  output logic [ADDR_W-IDX_W-1:0] cpu_tag,
  input  logic [IDX_W-1:0]        snp_idx,
  output line_st_e                snp_st,
  output logic [ADDR_W-IDX_W-1:0] snp_tag,
  input  logic                    fill_en,
  input  logic [IDX_W-1:0]        fill_idx,
  input  logic [ADDR_W-IDX_W-1:0] fill_tag,
  input  line_st_e                fill_st,
  input  logic                    upd_en,
  input  logic [IDX_W-1:0]        upd_idx,
  input  line_st_e                upd_st
);
  localparam int TAG_W  = ADDR_W - IDX_W;
  localparam int NLINES = 1 << IDX_W;

  line_st_e         st_vec  [NLINES];
  logic [TAG_W-1:0] tag_vec [NLINES];

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    line_st_e         st_q, st_d;
    logic [TAG_W-1:0] tag_q;
    logic             snp_sel, fill_sel;

    assign snp_sel  = upd_en  && (upd_idx  == IDX_W'(g));
    assign fill_sel = fill_en && (fill_idx == IDX_W'(g));

    always_comb begin
      st_d = st_q;
      if (snp_sel)       st_d = upd_st;
      else if (fill_sel) st_d = fill_st;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= LN_INV;
      else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
      if (fill_sel) tag_q <= fill_tag;
    end

    assign st_vec[g]  = st_q;
    assign tag_vec[g] = tag_q;

    AST_LEGAL_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      st_q != line_st_e'(2'b11)); // R1
  end

  assign cpu_st  = st_vec[cpu_idx];
  assign cpu_tag = tag_vec[cpu_idx];
  assign snp_st  = st_vec[snp_idx];
  assign snp_tag = tag_vec[snp_idx];

  AST_SNOOP_NOT_WITH_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |-> !upd_en); // R11

  AST_WM_LEAVES_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && upd_st == LN_INV) |=> st_vec[$past(upd_idx)] == LN_INV); // R8
endmodule

// File: rtl/coh_snoop_unit.sv
module coh_snoop_unit
  import coh_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int IDX_W  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    snp_valid,
  input  logic [1:0]              snp_cmd,
  input  logic [ADDR_W-1:0]       snp_addr,
  input  line_st_e                line_st,
  input  logic [ADDR_W-IDX_W-1:0] line_tag,
  output logic                    snp_match,
  output logic                    upd_en,
  output line_st_e                upd_st,
  output logic                    snp_abort,
  output logic [ADDR_W-1:0]       snp_wb_addr
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [TAG_W-1:0] req_tag;
  logic             cmd_rd, cmd_wr, dirty_hit;
  logic             abort_q;
  logic [ADDR_W-1:0] wb_addr_q;

  assign req_tag   = snp_addr[ADDR_W-1:IDX_W];
  assign cmd_rd    = (snp_cmd == BC_RDMISS);
  assign cmd_wr    = (snp_cmd == BC_WRMISS);
  assign snp_match = snp_valid && (cmd_rd || cmd_wr) &&
                     (line_st != LN_INV) && (line_tag == req_tag);
  assign dirty_hit = snp_match && (line_st == LN_EXC);
  assign upd_en    = snp_match && (cmd_wr || (line_st == LN_EXC));
  assign upd_st    = cmd_wr ? LN_INV : LN_SHR;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) abort_q <= 1'b0;
    else        abort_q <= dirty_hit;
  end

  always_ff @(posedge clk) begin
    if (dirty_hit) wb_addr_q <= snp_addr;
  end

  assign snp_abort   = abort_q;
  assign snp_wb_addr = wb_addr_q;

  AST_ABORT_AFTER_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
    snp_abort |-> $past(snp_valid)); // R7

  AST_ABORT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_abort && !$past(snp_valid, 2)) |=> !snp_abort || $past(snp_valid)); // R7
endmodule

// File: rtl/coh_cpu_fsm.sv
module coh_cpu_fsm
  import coh_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int IDX_W  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cpu_req_valid,
  input  logic                    cpu_req_write,
  input  logic [ADDR_W-1:0]       cpu_req_addr,
  input  line_st_e                line_st,
  input  logic [ADDR_W-IDX_W-1:0] line_tag,
  input  logic                    snp_valid,
  input  logic                    snp_pend_hit,
  input  logic                    bus_gnt,
  output logic                    cpu_done,
  output logic                    bus_req,
  output logic                    bus_cmd_valid,
  output logic [1:0]              bus_cmd,
  output logic [ADDR_W-1:0]       bus_cmd_addr,
  output logic                    fill_en,
  output line_st_e                fill_st,
  output logic [ADDR_W-IDX_W-1:0] fill_tag
);
  localparam int TAG_W = ADDR_W - IDX_W;

  fsm_e             st_q, st_d;
  logic [TAG_W-1:0] req_tag;
  logic [IDX_W-1:0] req_idx;
  logic             tag_eq, hit, need_wb, idle_hit, issue_miss;

  assign req_tag = cpu_req_addr[ADDR_W-1:IDX_W];
  assign req_idx = cpu_req_addr[IDX_W-1:0];
  assign tag_eq  = (line_tag == req_tag);
  assign hit     = (line_st != LN_INV) && tag_eq &&
                   (!cpu_req_write || (line_st == LN_EXC));
  assign need_wb = (line_st == LN_EXC) && !tag_eq;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      FS_IDLE: if (cpu_req_valid && !snp_valid && !hit) st_d = FS_ARB;
      FS_ARB: begin
        if (snp_valid)    st_d = snp_pend_hit ? FS_IDLE : FS_ARB;
        else if (bus_gnt) st_d = need_wb ? FS_WBK : FS_MISS;
      end
      FS_WBK: begin
        if (snp_valid) st_d = snp_pend_hit ? FS_IDLE : FS_WBK;
        else           st_d = FS_MISS;
      end
      FS_MISS: begin
        if (snp_valid) st_d = snp_pend_hit ? FS_IDLE : FS_MISS;
        else           st_d = FS_IDLE;
      end
      default: st_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= FS_IDLE;
    else        st_q <= st_d;
  end

  assign idle_hit   = (st_q == FS_IDLE) && cpu_req_valid && !snp_valid && hit;
  assign issue_miss = (st_q == FS_MISS) && !snp_valid;

  assign cpu_done      = idle_hit || issue_miss;
  assign bus_req       = (st_q != FS_IDLE);
  assign bus_cmd_valid = ((st_q == FS_WBK) || (st_q == FS_MISS)) && !snp_valid;

  always_comb begin
    if (st_q == FS_WBK) begin
      bus_cmd      = BC_WRBACK;
      bus_cmd_addr = {line_tag, req_idx};
    end else begin
      bus_cmd      = cpu_req_write ? BC_WRMISS : BC_RDMISS;
      bus_cmd_addr = cpu_req_addr;
    end
  end

  assign fill_en  = issue_miss;
  assign fill_st  = cpu_req_write ? LN_EXC : LN_SHR;
  assign fill_tag = req_tag;

  AST_GRANT_TO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == FS_ARB && bus_gnt && !snp_valid) |=> (bus_cmd_valid || snp_valid)); // R6

  AST_WB_THEN_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd_valid && bus_cmd == BC_WRBACK) |=>
      (snp_valid || (bus_cmd_valid && bus_cmd != BC_WRBACK))); // R5

  AST_SNOOP_STALLS_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> !cpu_done); // R11

  AST_HIT_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_done && !bus_cmd_valid) |-> !bus_req); // R2

  AST_DONE_RELEASES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_done && bus_cmd_valid) |=> !bus_cmd_valid); // R6
endmodule

// File: rtl/snoop_coh_ctrl.sv
module snoop_coh_ctrl
  import coh_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  output logic              cpu_done,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_cmd_valid,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_cmd_addr,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_abort,
  output logic [ADDR_W-1:0] snp_wb_addr
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic             rst_n_s;
  line_st_e         cpu_st, snp_st, fill_st, upd_st;
  logic [TAG_W-1:0] cpu_tag, snp_tag, fill_tag;
  logic             fill_en, upd_en, snp_match, snp_pend_hit;

  coh_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  coh_line_table #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_table (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .cpu_idx  (cpu_req_addr[IDX_W-1:0]),
    .cpu_st   (cpu_st),
    .cpu_tag  (cpu_tag),
    .snp_idx  (snp_addr[IDX_W-1:0]),
    .snp_st   (snp_st),
    .snp_tag  (snp_tag),
    .fill_en  (fill_en),
    .fill_idx (cpu_req_addr[IDX_W-1:0]),
    .fill_tag (fill_tag),
    .fill_st  (fill_st),
    .upd_en   (upd_en),
    .upd_idx  (snp_addr[IDX_W-1:0]),
    .upd_st   (upd_st)
  );

  coh_snoop_unit #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_snoop (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .snp_valid   (snp_valid),
    .snp_cmd     (snp_cmd),
    .snp_addr    (snp_addr),
    .line_st     (snp_st),
    .line_tag    (snp_tag),
    .snp_match   (snp_match),
    .upd_en      (upd_en),
    .upd_st      (upd_st),
    .snp_abort   (snp_abort),
    .snp_wb_addr (snp_wb_addr)
  );

  assign snp_pend_hit = snp_match &&
                        (snp_addr[IDX_W-1:0] == cpu_req_addr[IDX_W-1:0]);

  coh_cpu_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_fsm (
    .clk           (clk),
    .rst_n         (rst_n_s),
    .cpu_req_valid (cpu_req_valid),
    .cpu_req_write (cpu_req_write),
    .cpu_req_addr  (cpu_req_addr),
    .line_st       (cpu_st),
    .line_tag      (cpu_tag),
    .snp_valid     (snp_valid),
    .snp_pend_hit  (snp_pend_hit),
    .bus_gnt       (bus_gnt),
    .cpu_done      (cpu_done),
    .bus_req       (bus_req),
    .bus_cmd_valid (bus_cmd_valid),
    .bus_cmd       (bus_cmd),
    .bus_cmd_addr  (bus_cmd_addr),
    .fill_en       (fill_en),
    .fill_st       (fill_st),
    .fill_tag      (fill_tag)
  );
endmodule

// File: tb/test_snoop_coh_ctrl.sv
module test_snoop_coh_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cpu_req_valid, cpu_req_write;
  logic [AW-1:0] cpu_req_addr;
  logic          cpu_done, bus_req, bus_gnt, bus_cmd_valid;
  logic [1:0]    bus_cmd;
  logic [AW-1:0] bus_cmd_addr;
  logic          snp_valid;
  logic [1:0]    snp_cmd;
  logic [AW-1:0] snp_addr;
  logic          snp_abort;
  logic [AW-1:0] snp_wb_addr;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  // reference model: 0 Invalid, 1 Shared, 2 Exclusive
  int       mst  [4];
  bit [3:0] mtag [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  snoop_coh_ctrl #(.ADDR_W(AW), .IDX_W(2)) i_snoop_coh_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write),
    .cpu_req_addr(cpu_req_addr), .cpu_done(cpu_done),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd_valid(bus_cmd_valid),
    .bus_cmd(bus_cmd), .bus_cmd_addr(bus_cmd_addr),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .snp_abort(snp_abort), .snp_wb_addr(snp_wb_addr)
  );

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s t=%0t actual=0x%0h expected=0x%0h", r, $time, act, exp);
    end
  endtask

  function automatic bit m_hit(input bit w, input logic [5:0] a);
    int ix = int'(a[1:0]);
    return mst[ix] != 0 && mtag[ix] == a[5:2] && (!w || mst[ix] == 2);
  endfunction

  function automatic bit m_match(input logic [1:0] c, input logic [5:0] a);
    int ix = int'(a[1:0]);
    return (c == 2'd1 || c == 2'd2) && mst[ix] != 0 && mtag[ix] == a[5:2];
  endfunction

  function automatic bit m_abort(input logic [1:0] c, input logic [5:0] a);
    return m_match(c, a) && mst[int'(a[1:0])] == 2;
  endfunction

  task automatic m_apply(input logic [1:0] c, input logic [5:0] a);
    int ix = int'(a[1:0]);
    if (m_match(c, a)) begin
      if (c == 2'd2)         mst[ix] = 0;
      else if (mst[ix] == 2) mst[ix] = 1;
    end
  endtask

  task automatic cpu_op(input bit w, input logic [5:0] a, input int gd,
                        input bit inj, input logic [1:0] sc, input logic [5:0] sa,
                        input string lbl);
    int       ix = int'(a[1:0]);
    bit       pend, eab, wbx;
    logic [1:0] ecmd;
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_write = w; cpu_req_addr = a;
    #1;
    if (m_hit(w, a)) begin
      chk(cpu_done == 1'b1, "R2 hit done", int'(cpu_done), 1);
      chk(bus_req == 1'b0, "R2 hit quiet bus", int'(bus_req), 0);
      @(posedge clk); #1;
      cpu_req_valid = 1'b0;
      return;
    end
    chk(cpu_done == 1'b0, lbl, int'(cpu_done), 0);
    @(posedge clk); @(negedge clk);
    chk(bus_req && !bus_cmd_valid, "R6 request raised", int'({bus_req, bus_cmd_valid}), 2);
    if (inj) begin
      snp_valid = 1'b1; snp_cmd = sc; snp_addr = sa;
      pend = m_match(sc, sa) && (sa[1:0] == a[1:0]);
      eab  = m_abort(sc, sa);
      m_apply(sc, sa);
      @(posedge clk); @(negedge clk);
      snp_valid = 1'b0;
      chk(snp_abort == eab, "R10 snoop while waiting abort", int'(snp_abort), int'(eab));
      if (pend) begin
        chk(bus_req == 1'b0, "R10 restart drops request", int'(bus_req), 0);
        @(posedge clk); @(negedge clk);
      end
      chk(bus_req == 1'b1, "R10 request active", int'(bus_req), 1);
    end
    for (int i = 0; i < gd; i++) begin
      @(posedge clk); @(negedge clk);
      chk(bus_req && !bus_cmd_valid && !cpu_done, "R6 waiting for grant",
          int'({bus_req, bus_cmd_valid, cpu_done}), 4);
    end
    bus_gnt = 1'b1;
    wbx = (mst[ix] == 2) && (mtag[ix] != a[5:2]);
    @(posedge clk); @(negedge clk);
    bus_gnt = 1'b0;
    if (wbx) begin
      chk(bus_cmd_valid && bus_cmd == 2'd3 && bus_cmd_addr == {mtag[ix], a[1:0]},
          "R5 victim write-back", int'({bus_cmd_valid, bus_cmd, bus_cmd_addr}),
          int'({1'b1, 2'd3, mtag[ix], a[1:0]}));
      chk(cpu_done == 1'b0, "R5 not done during write-back", int'(cpu_done), 0);
      @(posedge clk); @(negedge clk);
    end
    ecmd = w ? 2'd2 : 2'd1;
    chk(bus_cmd_valid && bus_cmd == ecmd && bus_cmd_addr == a,
        w ? "R4 write miss command" : "R3 read miss command",
        int'({bus_cmd_valid, bus_cmd, bus_cmd_addr}), int'({1'b1, ecmd, a}));
    chk(cpu_done == 1'b1, w ? "R4 done with miss" : "R3 done with miss", int'(cpu_done), 1);
    @(posedge clk);
    mst[ix] = w ? 2 : 1; mtag[ix] = a[5:2];
    #1 cpu_req_valid = 1'b0;
    @(negedge clk);
    chk(!bus_req && !bus_cmd_valid, "R6 bus released", int'({bus_req, bus_cmd_valid}), 0);
  endtask

  task automatic snoop_op(input logic [1:0] c, input logic [5:0] a);
    bit m, eab;
    @(negedge clk);
    snp_valid = 1'b1; snp_cmd = c; snp_addr = a;
    m = m_match(c, a); eab = m_abort(c, a);
    m_apply(c, a);
    @(posedge clk); @(negedge clk);
    snp_valid = 1'b0;
    if (!m)           chk(snp_abort == 1'b0, "R9 unmatched snoop no abort", int'(snp_abort), 0);
    else if (c == 2'd1) chk(snp_abort == eab, "R7 snooped read abort", int'(snp_abort), int'(eab));
    else              chk(snp_abort == eab, "R8 snooped write abort", int'(snp_abort), int'(eab));
    if (eab) chk(snp_wb_addr == a, "R7 supplied block address", int'(snp_wb_addr), int'(a));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0C0C));
    for (int i = 0; i < 4; i++) begin mst[i] = 0; mtag[i] = 4'd0; end
    rst_n = 1'b0; cpu_req_valid = 1'b0; cpu_req_write = 1'b0; cpu_req_addr = '0;
    bus_gnt = 1'b0; snp_valid = 1'b0; snp_cmd = 2'd0; snp_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(!bus_req && !bus_cmd_valid && !snp_abort && !cpu_done, "R1 outputs after reset",
        int'({bus_req, bus_cmd_valid, snp_abort, cpu_done}), 0);

    // directed sequence
    cpu_op(0, 6'h04, 1, 0, 2'd0, 6'h00, "R1 first read misses");
    cpu_op(0, 6'h04, 0, 0, 2'd0, 6'h00, "R2");
    cpu_op(1, 6'h04, 2, 0, 2'd0, 6'h00, "R4 write to Shared misses");
    cpu_op(1, 6'h04, 0, 0, 2'd0, 6'h00, "R2");
    cpu_op(0, 6'h04, 0, 0, 2'd0, 6'h00, "R2");
    cpu_op(0, 6'h08, 0, 0, 2'd0, 6'h00, "R5 dirty victim read");
    cpu_op(1, 6'h0C, 1, 0, 2'd0, 6'h00, "R4 clean victim write");
    cpu_op(1, 6'h10, 3, 0, 2'd0, 6'h00, "R5 dirty victim write");
    snoop_op(2'd1, 6'h10);
    snoop_op(2'd1, 6'h14);
    snoop_op(2'd2, 6'h11);
    snoop_op(2'd3, 6'h10);
    cpu_op(0, 6'h10, 0, 0, 2'd0, 6'h00, "R9 line survives ignored snoops");
    snoop_op(2'd1, 6'h10);
    snoop_op(2'd2, 6'h10);
    cpu_op(0, 6'h10, 0, 0, 2'd0, 6'h00, "R8 invalidated line misses");
    cpu_op(1, 6'h21, 1, 0, 2'd0, 6'h00, "R4 write to Invalid");
    snoop_op(2'd2, 6'h21);
    cpu_op(1, 6'h22, 0, 0, 2'd0, 6'h00, "R4 write to Invalid");
    cpu_op(0, 6'h26, 1, 1, 2'd1, 6'h22, "R10 pending victim snooped");
    cpu_op(0, 6'h03, 1, 1, 2'd2, 6'h26, "R10 other-line snoop");
    cpu_op(0, 6'h03, 0, 0, 2'd0, 6'h00, "R2");

    // R11: snoop and CPU hit in the same cycle
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_write = 1'b0; cpu_req_addr = 6'h03;
    snp_valid = 1'b1; snp_cmd = 2'd1; snp_addr = 6'h3F;
    m_apply(2'd1, 6'h3F);
    #1 chk(cpu_done == 1'b0, "R11 CPU stalled by snoop", int'(cpu_done), 0);
    @(posedge clk); @(negedge clk);
    snp_valid = 1'b0;
    #1 chk(cpu_done == 1'b1, "R11 CPU proceeds after snoop", int'(cpu_done), 1);
    @(posedge clk); #1 cpu_req_valid = 1'b0;

    // random traffic
    for (int n = 0; n < 400; n++) begin
      int sel = int'($urandom_range(0, 99));
      logic [5:0] ra = {2'b00, 2'($urandom_range(0, 2)), 2'($urandom_range(0, 3))};
      logic [5:0] sa = {2'b00, 2'($urandom_range(0, 2)), 2'($urandom_range(0, 3))};
      logic [1:0] sc = 2'($urandom_range(0, 3));
      if (sel < 65) begin
        cpu_op(bit'($urandom_range(0, 1)), ra, int'($urandom_range(0, 3)),
               ($urandom_range(0, 9) < 3), sc, sa, "R3 random miss not done early");
      end else begin
        snoop_op(sc, sa);
      end
    end

    repeat (2) @(posedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule